// File: doc/BRIEF.md
# Dual-Width Integer ALU with Carry and Zero Flags

This block is the integer execution unit of a small 16-bit processor. Each issued operation works at one of two widths. In word mode it works on the full 16-bit operands. In byte mode it works on the low byte only. Operand A carries the value of the destination register, and operand B carries the second source. For multiply and divide, the caller places the implicit accumulator on operand A. The block computes the result combinationally and registers it. On the clock edge that follows an issue, it also updates its carry and zero flags.

Merging a byte result into one half of a register is left to the caller, and so is operand fetch. The block returns a zero-extended result and a one-cycle write strobe. A division by zero raises a one-cycle trap instead of producing a result.

Top module: `dualw_alu`

## Requirements
- R1: On the rising edge after `issue` is sampled high, the block registers `res`, `res_we` and `div_trap`, and it updates `carry` and `zero` when the operation is one that updates them. `res_we` and `div_trap` are high for that one cycle only. While `issue` is low, `carry` and `zero` keep their values.
- R2: Add (code 0) stores A+B truncated to the width. Increment (code 3) stores A+1 and ignores B. For both, C is the carry out of the selected width.
- R3: Subtract (code 1) stores A-B truncated to the width. Decrement (code 4) stores A-1 and ignores B. For both, C is the unsigned borrow.
- R4: Compare (code 2) never asserts `res_we`. It sets C=1,Z=0 when A<B unsigned, C=0,Z=1 when A=B, and C=0,Z=0 when A>B.
- R5: Multiply (code 5) stores the product truncated to the width. C is set when the product does not fit in the width.
- R6: Divide (code 6) stores the unsigned quotient with C=0. A zero divisor instead pulses `div_trap`, keeps `res_we` low and leaves C and Z unchanged.
- R7: AND (7), OR (8), XOR (9) and NOT of A (10) store their result and leave C and Z unchanged.
- R8: Shift left (11) and logical shift right (12) move A by the unsigned count B and fill with zeros. C is the last bit shifted out. A count of 0 leaves the value as it is and clears C. A count equal to or above the width gives 0, and in that case C is the last bit out (count equal to width) or 0 (count above width).
- R9: In byte mode (`byte_mode`=1), only bits 7:0 of A and B take part, and bits 15:8 of `res` are 0.
- R10: For every operation that updates the flags, Z is 1 exactly when the width-truncated result is zero.
- R11: After reset, `res`, `res_we`, `carry`, `zero` and `div_trap` are all 0. Codes 13 to 15 are reserved: they assert neither `res_we` nor `div_trap`, and they leave C and Z unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Operation valid this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| opnd_a | input | 16 | Destination register value / accumulator |
| opnd_b | input | 16 | Second source, shift count or divisor |
| res | output | 16 | Registered, zero-extended result |
| res_we | output | 1 | One-cycle write strobe for `res` |
| carry | output | 1 | Carry/borrow flag |
| zero | output | 1 | Zero flag |
| div_trap | output | 1 | One-cycle divide-by-zero exception |

## Verification
Every result, strobe, flag and trap is due exactly one clock edge after the issuing cycle, because a single register stage sits between the operands and the outputs. The bench drives each operation on a falling edge and holds `issue` through one rising edge. It reads all outputs at the next falling edge, before it drives the next vector, so each check sees exactly one operation. The bench also follows the flag state across vectors that must not touch it. Idle cycles with `issue` low confirm that the strobes have dropped and the flags have held.

// File: rtl/dualw_alu_pkg.sv
package dualw_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_CMP = 4'd2, OP_INC = 4'd3,
    OP_DEC = 4'd4, OP_MUL = 4'd5, OP_DIV = 4'd6, OP_AND = 4'd7,
    OP_OR  = 4'd8, OP_XOR = 4'd9, OP_NOT = 4'd10, OP_SHL = 4'd11,
    OP_SHR = 4'd12
  } alu_op_e;

  function automatic logic is_arith(input logic [3:0] op);
    return op <= 4'd6;
  endfunction

  function automatic logic is_logic(input logic [3:0] op);
    return (op >= 4'd7) && (op <= 4'd10);
  endfunction

  function automatic logic is_shift(input logic [3:0] op);
    return (op == 4'd11) || (op == 4'd12);
  endfunction
endpackage

// File: rtl/dualw_alu_arith.sv
module dualw_alu_arith
  import dualw_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic         narrow,
  input  logic [W-1:0] a_m,
  input  logic [W-1:0] b_m,
  output logic [W-1:0] y,
  output logic         c_out,
  output logic         trap
);
  localparam int HW = W / 2;

  logic [W-1:0]   b_eff;
  logic [W:0]     sum;
  logic [W:0]     diff;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quot;

  always_comb begin
    b_eff = ((op == OP_INC) || (op == OP_DEC)) ? W'(1) : b_m;
    sum   = {1'b0, a_m} + {1'b0, b_eff};
    diff  = {1'b0, a_m} - {1'b0, b_eff};
    prod  = {{W{1'b0}}, a_m} * {{W{1'b0}}, b_m};
    quot  = (b_m == '0) ? '0 : (a_m / b_m);
    trap  = (op == OP_DIV) && (b_m == '0);
    y     = '0;
    c_out = 1'b0;
    case (op)
      OP_ADD, OP_INC: begin
        y     = sum[W-1:0];
        c_out = narrow ? sum[HW] : sum[W];
      end
      OP_SUB, OP_DEC, OP_CMP: begin
        y     = diff[W-1:0];
        c_out = diff[W];
      end
      OP_MUL: begin
        y     = prod[W-1:0];
        c_out = narrow ? (|prod[W-1:HW]) : (|prod[2*W-1:W]);
      end
      OP_DIV: begin
        y     = quot;
        c_out = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dualw_alu_logic.sv
module dualw_alu_logic
  import dualw_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a_m,
  input  logic [W-1:0] b_m,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_AND:  y = a_m & b_m;
      OP_OR:   y = a_m | b_m;
      OP_XOR:  y = a_m ^ b_m;
      OP_NOT:  y = ~a_m;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dualw_alu_shift.sv
module dualw_alu_shift
  import dualw_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic         narrow,
  input  logic [W-1:0] a_m,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] y,
  output logic         c_out
);
  localparam int HW = W / 2;

  logic [W:0] left_x;
  logic [W:0] right_x;

  always_comb begin
    left_x  = {1'b0, a_m} << cnt;
    right_x = {a_m, 1'b0} >> cnt;
    if (op == OP_SHL) begin
      y     = left_x[W-1:0];
      c_out = narrow ? left_x[HW] : left_x[W];
    end else begin
      y     = right_x[W:1];
      c_out = right_x[0];
    end
  end
endmodule

// File: rtl/dualw_alu.sv
module dualw_alu
  import dualw_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic [3:0]   op_sel,
  input  logic         byte_mode,
  input  logic [15:0]  opnd_a,
  input  logic [15:0]  opnd_b,
  output logic [15:0]  res,
  output logic         res_we,
  output logic         carry,
  output logic         zero,
  output logic         div_trap
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] LO_MASK = {{HW{1'b0}}, {HW{1'b1}}};

  logic [W-1:0] a_m, b_m;
  logic [W-1:0] y_ar, y_lg, y_sh, y_sel, y_trunc;
  logic         c_ar, c_sh, c_sel, trap_ar;
  logic         op_known, do_write, do_flags;

  assign a_m = byte_mode ? (opnd_a & LO_MASK) : opnd_a;
  assign b_m = byte_mode ? (opnd_b & LO_MASK) : opnd_b;

  dualw_alu_arith #(.W(W)) u_arith (
    .op(op_sel), .narrow(byte_mode), .a_m(a_m), .b_m(b_m),
    .y(y_ar), .c_out(c_ar), .trap(trap_ar)
  );

  dualw_alu_logic #(.W(W)) u_logic (
    .op(op_sel), .a_m(a_m), .b_m(b_m), .y(y_lg)
  );

  dualw_alu_shift #(.W(W)) u_shift (
    .op(op_sel), .narrow(byte_mode), .a_m(a_m), .cnt(b_m),
    .y(y_sh), .c_out(c_sh)
  );

  always_comb begin
    op_known = is_arith(op_sel) || is_logic(op_sel) || is_shift(op_sel);
    if (is_shift(op_sel)) begin
      y_sel = y_sh;
      c_sel = c_sh;
    end else if (is_logic(op_sel)) begin
      y_sel = y_lg;
      c_sel = 1'b0;
    end else begin
      y_sel = y_ar;
      c_sel = c_ar;
    end
    if (!op_known || trap_ar) y_sel = '0;
    y_trunc  = byte_mode ? (y_sel & LO_MASK) : y_sel;
    do_write = op_known && !trap_ar && (op_sel != OP_CMP);
    do_flags = op_known && !trap_ar && !is_logic(op_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res      <= '0;
      res_we   <= 1'b0;
      carry    <= 1'b0;
      zero     <= 1'b0;
      div_trap <= 1'b0;
    end else begin
      res_we   <= issue && do_write;
      div_trap <= issue && trap_ar;
      if (issue) res <= y_trunc;
      if (issue && do_flags) begin
        carry <= c_sel;
        zero  <= (y_trunc == '0);
      end
    end
  end

  // R1
  we_needs_issue_chk: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(issue));
  // R1
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !issue |=> $stable({carry, zero}));
  // R4
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && op_sel == OP_CMP) |=> !res_we);
  // R6
  trap_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    div_trap |-> !res_we);
  // R6
  trap_only_div_chk: assert property (@(posedge clk) disable iff (rst)
    div_trap |-> ($past(op_sel) == OP_DIV));
  // R9
  byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && byte_mode) |=> (res[W-1:HW] == '0));
endmodule

// File: tb/dualw_alu_bench.sv
`timescale 1ns/1ps
module dualw_alu_bench;
  typedef struct packed {
    logic [3:0]  op;
    logic        bm;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] r;
    logic        we;
    logic        fl;
    logic        c;
    logic        z;
    logic        tr;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{4'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R2 R10
    '{4'd0, 1'b1, 16'h12F0, 16'h3415, 16'h0005, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 R9
    '{4'd0, 1'b0, 16'h7000, 16'h1000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd1, 1'b0, 16'h0005, 16'h0007, 16'hFFFE, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd1, 1'b1, 16'hAB10, 16'hCD10, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 R9
    '{4'd2, 1'b0, 16'h1234, 16'h1234, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R4
    '{4'd2, 1'b0, 16'h0001, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
    '{4'd2, 1'b1, 16'h0080, 16'hFF7F, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 R9
    '{4'd3, 1'b1, 16'h00FF, 16'h1234, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R2
    '{4'd4, 1'b0, 16'h0000, 16'h5555, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd4, 1'b1, 16'h3300, 16'h0000, 16'h00FF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd5, 1'b0, 16'h0100, 16'h0100, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R5
    '{4'd5, 1'b1, 16'h0010, 16'h000F, 16'h00F0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd5, 1'b1, 16'h0010, 16'h0010, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R5
    '{4'd6, 1'b0, 16'h0064, 16'h0007, 16'h000E, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd6, 1'b1, 16'h00FF, 16'h0010, 16'h000F, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd7, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
    '{4'd6, 1'b0, 16'h1234, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6
    '{4'd6, 1'b1, 16'hFF03, 16'h0100, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 R9
    '{4'd8, 1'b1, 16'h12A0, 16'h340B, 16'h00AB, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
    '{4'd9, 1'b0, 16'hA5A5, 16'hFFFF, 16'h5A5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
    '{4'd10,1'b1, 16'h1234, 16'h0000, 16'h00CB, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
    '{4'd11,1'b0, 16'h8001, 16'h0001, 16'h0002, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R8
    '{4'd11,1'b1, 16'h0081, 16'h0001, 16'h0002, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R8
    '{4'd12,1'b0, 16'h0003, 16'h0002, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 R10
    '{4'd11,1'b0, 16'h1234, 16'h0000, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd12,1'b0, 16'h8000, 16'h0010, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R8
    '{4'd11,1'b1, 16'h00FF, 16'h0009, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R8
    '{4'd12,1'b1, 16'h0080, 16'h0008, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R8
    '{4'd13,1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R11
    '{4'd15,1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R11
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue = 1'b0;
  logic [3:0] op_sel = '0;
  logic byte_mode = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] res;
  logic res_we, carry, zero, div_trap;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic exp_c = 1'b0, exp_z = 1'b0;

  always #2.5 clk = ~clk;

  dualw_alu u_dualw_alu (
    .clk(clk), .rst(rst), .issue(issue), .op_sel(op_sel),
    .byte_mode(byte_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res(res), .res_we(res_we), .carry(carry), .zero(zero),
    .div_trap(div_trap)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(res == 16'h0, "R11 res after reset", res, 16'h0);
    chk({res_we, carry, zero, div_trap} == 4'b0, "R11 strobes/flags after reset",
        {12'h0, res_we, carry, zero, div_trap}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      op_sel = TBL[i].op; byte_mode = TBL[i].bm;
      opnd_a = TBL[i].a;  opnd_b = TBL[i].b;
      issue  = 1'b1;
      @(negedge clk);
      if (TBL[i].fl) begin
        exp_c = TBL[i].c; exp_z = TBL[i].z;
      end
      chk(res_we == TBL[i].we, $sformatf("R1 vec%0d op%0d res_we", i, TBL[i].op),
          {15'h0, res_we}, {15'h0, TBL[i].we});
      chk(div_trap == TBL[i].tr, $sformatf("R6 vec%0d op%0d div_trap", i, TBL[i].op),
          {15'h0, div_trap}, {15'h0, TBL[i].tr});
      if (TBL[i].we)
        chk(res == TBL[i].r, $sformatf("R2-R9 vec%0d op%0d res", i, TBL[i].op),
            res, TBL[i].r);
      chk(carry == exp_c, $sformatf("R10 vec%0d op%0d carry", i, TBL[i].op),
          {15'h0, carry}, {15'h0, exp_c});
      chk(zero == exp_z, $sformatf("R10 vec%0d op%0d zero", i, TBL[i].op),
          {15'h0, zero}, {15'h0, exp_z});
    end

    // R1: idle cycles drop strobes and hold flags; set flags to C=1,Z=1 first
    op_sel = 4'd0; byte_mode = 1'b0; opnd_a = 16'hFFFF; opnd_b = 16'h0001;
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0; opnd_a = 16'h0001; opnd_b = 16'h0001;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(res_we == 1'b0, "R1 idle res_we", {15'h0, res_we}, 16'h0);
      chk({carry, zero} == 2'b11, "R1 idle flags hold", {14'h0, carry, zero}, 16'h3);
    end

    // R4 compare leaves stored result untouched at port: res_we low, flags A<B
    op_sel = 4'd2; opnd_a = 16'h0002; opnd_b = 16'h0003; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    chk({res_we, carry, zero} == 3'b010, "R4 compare below",
        {13'h0, res_we, carry, zero}, 16'h2);

    // R11 reset mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk({res, res_we, carry, zero, div_trap} == 20'h0, "R11 re-reset",
        res, 16'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule